// File: doc/BRIEF.md
# Johnson Octal Counter with Decoded Outputs

This block counts advance events modulo eight and presents the current count as a one-hot set of eight phase lines. A carry line lets several counters be chained for wider division. The count is held in a four-bit twisted-ring register. Each phase line is formed from just two adjacent ring bits, so no binary decode is needed. The phase and carry lines are registered so that they never glitch.

The two count pins, `countClk` and `inhibit`, are asynchronous to the system clock `clk`. Each passes through a synchronizer before edge detection. An advance event is either of these:
- a rising `countClk` edge while `inhibit` is low;
- a falling `inhibit` edge while `countClk` is high.

With this pair of rules, `inhibit` can serve either as a gate on the count clock or as a clock of its own with inverted sense. The active-high `clear` pin resets the block asynchronously, and its release is synchronized.

Top module: `johnson_octal_counter`

## Requirements
- R1: While `clear` is high, `phase` is 8'b0000_0001 and `carryOut` is 1, with no clock edge needed, and pin activity does not advance the count. After release, the count is 0 until the next advance event.
- R2: `phase` has exactly one bit set at all times outside reset, and bit i is set when the count is i.
- R3: A rising edge on `countClk` while `inhibit` is low advances the count by one. The outputs change on the 4th `clk` rising edge after the pin change.
- R4: A falling edge on `inhibit` while `countClk` is high advances the count by one, with the same latency as R3.
- R5: The count holds in each of these cases: `countClk` rises while `inhibit` is high, `countClk` falls, `inhibit` rises, or `inhibit` falls while `countClk` is low.
- R6: Successive advances step the count 0,1,2,...,7 and then wrap to 0.
- R7: `carryOut` is 1 for counts 0 to 3 and 0 for counts 4 to 7, so it rises only when the count wraps from 7 to 0.
- R8: If the ring register holds one of the eight patterns outside the valid sequence, the outputs keep their last valid value. The next advance event brings the count to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that samples the pins |
| clear | input | 1 | Active-high asynchronous reset to count 0 |
| countClk | input | 1 | Count clock pin (asynchronous) |
| inhibit | input | 1 | Count gate, which also acts as an alternate clock on its falling edge (asynchronous) |
| phase | output | 8 | One-hot decoded count |
| carryOut | output | 1 | High for counts 0 to 3 |

## Verification
The hardest condition to reach is an invalid ring pattern, because no sequence of pin activity can produce one. The bench therefore forces the ring register to an invalid pattern for one cycle, releases it, and checks two things at the ports: the outputs hold their last valid value, and one advance event then gives count 0. The second advance mode and the four hold cases are reached by a vector table. The table drives the two pins through every ordering of their edges and gives each step enough system cycles to pass through the synchronizers.

// File: rtl/jc_pkg.sv
package jc_pkg;
  // strobes from the control half to the datapath half
  typedef struct packed {
    logic advance;
  } strobe_t;
endpackage

// File: rtl/jc_control.sv
module jc_control #(
  parameter int SYNC_STAGES = 2,
  parameter int RST_STAGES  = 2
) (
  input  logic              clk,
  input  logic              clear,
  input  logic              countClk,
  input  logic              inhibit,
  output logic              rstInt,
  output jc_pkg::strobe_t   strobe
);
  localparam int PINS = 2;   // bit 1: count clock, bit 0: inhibit

  // reset: asserted at once, released after RST_STAGES clock edges
  logic [RST_STAGES-1:0] rstPipe;
  always_ff @(posedge clk or posedge clear) begin
    if (clear) rstPipe <= '1;
    else       rstPipe <= {rstPipe[RST_STAGES-2:0], 1'b0};
  end
  assign rstInt = rstPipe[RST_STAGES-1];

  logic [PINS-1:0] pinRaw;
  logic [PINS-1:0] pinSync;
  logic [PINS-1:0] pinPrev;
  assign pinRaw = {countClk, inhibit};

  for (genvar p = 0; p < PINS; p++) begin : g_sync
    logic [SYNC_STAGES-1:0] chain;
    always_ff @(posedge clk) chain <= {chain[SYNC_STAGES-2:0], pinRaw[p]};
    assign pinSync[p] = chain[SYNC_STAGES-1];
  end

  always_ff @(posedge clk) pinPrev <= pinSync;

  logic clkRise, enFall;
  assign clkRise = pinSync[1] & ~pinPrev[1];
  assign enFall  = ~pinSync[0] & pinPrev[0];

  always_comb begin
    strobe.advance = ~rstInt & ((clkRise & ~pinSync[0]) | (enFall & pinSync[1]));
  end
endmodule

// File: rtl/jc_datapath.sv
module jc_datapath #(
  parameter  int STAGES = 4,
  localparam int COUNT  = 2 * STAGES
) (
  input  logic              clk,
  input  logic              rstInt,
  input  jc_pkg::strobe_t   strobe,
  output logic [STAGES-1:0] stateQ,
  output logic [COUNT-1:0]  phase,
  output logic              carryOut
);
  // a valid ring pattern has at most one boundary between adjacent bits
  function automatic logic legalRing(input logic [STAGES-1:0] s);
    int edges;
    edges = 0;
    for (int i = 1; i < STAGES; i++) if (s[i] != s[i-1]) edges++;
    return edges <= 1;
  endfunction

  logic                legalNow;
  logic [STAGES-1:0]   stateNext;
  logic [COUNT-1:0]    decodeW;

  assign legalNow = legalRing(stateQ);

  always_comb begin
    if (legalNow) stateNext = {stateQ[STAGES-2:0], ~stateQ[STAGES-1]};
    else          stateNext = '0;
  end

  always_ff @(posedge clk or posedge rstInt) begin
    if (rstInt)              stateQ <= '0;
    else if (strobe.advance) stateQ <= stateNext;
  end

  // two-bit decode: end stages for 0 and STAGES, adjacent boundaries elsewhere
  assign decodeW[0]      = ~stateQ[0] & ~stateQ[STAGES-1];
  assign decodeW[STAGES] =  stateQ[0] &  stateQ[STAGES-1];
  for (genvar i = 1; i < STAGES; i++) begin : g_dec
    assign decodeW[i]        =  stateQ[i-1] & ~stateQ[i];
    assign decodeW[STAGES+i] = ~stateQ[i-1] &  stateQ[i];
  end

  always_ff @(posedge clk or posedge rstInt) begin
    if (rstInt) begin
      phase    <= COUNT'(1);
      carryOut <= 1'b1;
    end else if (legalNow) begin
      phase    <= decodeW;
      carryOut <= ~stateQ[STAGES-1];
    end
  end
endmodule

// File: rtl/johnson_octal_counter.sv
module johnson_octal_counter #(
  parameter  int STAGES      = 4,
  parameter  int SYNC_STAGES = 2,
  localparam int COUNT       = 2 * STAGES
) (
  input  logic             clk,
  input  logic             clear,
  input  logic             countClk,
  input  logic             inhibit,
  output logic [COUNT-1:0] phase,
  output logic             carryOut
);
  jc_pkg::strobe_t   strobe;
  logic              rstInt;
  logic              advanceW;
  logic [STAGES-1:0] stateBus;

  jc_control #(.SYNC_STAGES(SYNC_STAGES), .RST_STAGES(2)) u_ctrl (
    .clk(clk), .clear(clear), .countClk(countClk), .inhibit(inhibit),
    .rstInt(rstInt), .strobe(strobe)
  );

  jc_datapath #(.STAGES(STAGES)) u_dp (
    .clk(clk), .rstInt(rstInt), .strobe(strobe),
    .stateQ(stateBus), .phase(phase), .carryOut(carryOut)
  );

  assign advanceW = strobe.advance;
endmodule

// File: rtl/jc_counter_chk.sv
module jc_counter_chk #(
  parameter  int STAGES = 4,
  localparam int COUNT  = 2 * STAGES
) (
  input logic              clk,
  input logic              clear,
  input logic              advance,
  input logic [STAGES-1:0] stateQ,
  input logic [COUNT-1:0]  phase,
  input logic              carryOut
);
  function automatic logic ringOk(input logic [STAGES-1:0] s);
    int n;
    n = 0;
    for (int i = 1; i < STAGES; i++) if (s[i] != s[i-1]) n++;
    return n <= 1;
  endfunction

  // R1
  clear_forces_zero_chk: assert property (@(posedge clk)
    clear |=> (phase == COUNT'(1)) && carryOut);

  // R2
  phase_onehot_chk: assert property (@(posedge clk) disable iff (clear)
    $onehot(phase));

  // R7
  carry_low_half_chk: assert property (@(posedge clk) disable iff (clear)
    carryOut == (|phase[COUNT/2-1:0]));

  // R7
  carry_rise_wrap_chk: assert property (@(posedge clk) disable iff (clear)
    $rose(carryOut) |-> phase[0]);

  // R8
  illegal_recover_chk: assert property (@(posedge clk) disable iff (clear)
    (advance && !ringOk(stateQ)) |=> (stateQ == '0));
endmodule

bind johnson_octal_counter jc_counter_chk #(.STAGES(STAGES)) u_chk (
  .clk(clk), .clear(clear), .advance(advanceW), .stateQ(stateBus),
  .phase(phase), .carryOut(carryOut)
);

// File: tb/johnson_octal_counter_bench.sv
module johnson_octal_counter_bench;
  localparam int PERIOD = 10;
  localparam int SETTLE = 6;
  localparam int NVEC   = 21;
  // {countClk, inhibit, expected count}
  localparam logic [4:0] VEC [NVEC] = '{
    {2'b10, 3'd1}, // R3 rise, inhibit low
    {2'b00, 3'd1}, // R5 falling clock holds
    {2'b10, 3'd2}, // R3
    {2'b11, 3'd2}, // R5 inhibit rise holds
    {2'b10, 3'd3}, // R4 inhibit fall, clock high
    {2'b00, 3'd3},
    {2'b01, 3'd3},
    {2'b11, 3'd3}, // R5 rise while inhibited
    {2'b01, 3'd3},
    {2'b00, 3'd3}, // R5 inhibit fall, clock low
    {2'b10, 3'd4}, // R7 carry drops
    {2'b11, 3'd4},
    {2'b10, 3'd5}, // R4
    {2'b00, 3'd5},
    {2'b10, 3'd6},
    {2'b00, 3'd6},
    {2'b10, 3'd7},
    {2'b00, 3'd7},
    {2'b10, 3'd0}, // R6 wrap, carry rises
    {2'b00, 3'd0},
    {2'b10, 3'd1}
  };

  logic clk = 1'b0;
  logic clear = 1'b1;
  logic countClk = 1'b0;
  logic inhibit = 1'b0;
  logic [7:0] phase;
  logic carryOut;
  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #(PERIOD/2) clk = ~clk;

  johnson_octal_counter u_johnson_octal_counter (
    .clk(clk), .clear(clear), .countClk(countClk), .inhibit(inhibit),
    .phase(phase), .carryOut(carryOut)
  );

  task automatic waitCycles(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic setPins(input logic c, input logic i);
    @(negedge clk);
    countClk = c;
    inhibit  = i;
    waitCycles(SETTLE);
  endtask

  task automatic expectCount(input string tag, input int cnt);
    logic [7:0] expPhase;
    logic expCarry;
    expPhase = 8'b1 << cnt;
    expCarry = (cnt < 4);
    checks++;
    if (phase !== expPhase) begin
      fails++;
      $display("FAIL %s phase actual %b expected %b", tag, phase, expPhase);
    end
    checks++;
    if (carryOut !== expCarry) begin
      fails++;
      $display("FAIL %s carry actual %b expected %b", tag, carryOut, expCarry);
    end
  endtask

  initial begin
    waitCycles(4);
    expectCount("R1 reset state", 0);
    @(negedge clk) clear = 1'b0;
    waitCycles(SETTLE);
    expectCount("R1 after release", 0);

    // table walk: R2 R3 R4 R5 R6 R7
    for (int v = 0; v < NVEC; v++) begin
      setPins(VEC[v][4], VEC[v][3]);
      expectCount($sformatf("R2 R3 R4 R5 R6 R7 vector %0d", v), int'(VEC[v][2:0]));
    end

    // R1 reset in mid-count (count 1 now, clock high)
    setPins(1'b0, 1'b0);
    for (int p = 0; p < 4; p++) begin
      setPins(1'b1, 1'b0);
      setPins(1'b0, 1'b0);
    end
    expectCount("R6 reached count 5", 5);
    @(negedge clk) clear = 1'b1;
    #1;
    expectCount("R1 async clear", 0);
    setPins(1'b1, 1'b0);
    setPins(1'b0, 1'b0);
    expectCount("R1 pins ignored in clear", 0);
    @(negedge clk) clear = 1'b0;
    waitCycles(SETTLE);
    expectCount("R1 released", 0);
    setPins(1'b1, 1'b0);
    expectCount("R3 first advance after clear", 1);

    // R8 invalid ring pattern
    @(negedge clk) force u_johnson_octal_counter.u_dp.stateQ = 4'b0101;
    @(negedge clk) release u_johnson_octal_counter.u_dp.stateQ;
    waitCycles(3);
    expectCount("R8 outputs hold on invalid", 1);
    setPins(1'b0, 1'b0);
    setPins(1'b1, 1'b0);
    expectCount("R8 recovery from 0101", 0);
    @(negedge clk) force u_johnson_octal_counter.u_dp.stateQ = 4'b1001;
    @(negedge clk) release u_johnson_octal_counter.u_dp.stateQ;
    setPins(1'b1, 1'b1);
    setPins(1'b1, 1'b0);
    expectCount("R8 recovery from 1001 via inhibit", 0);
    setPins(1'b0, 1'b0);
    setPins(1'b1, 1'b0);
    expectCount("R6 normal after recovery", 1);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

  initial begin
    #(PERIOD * 100000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", checks, fails);
      $finish;
    end
  end
endmodule